// File: doc/BRIEF.md
# Multicart Extended Bank Register Decoder

This block sits on the CPU write path of a multicart bank-switching cartridge controller. It holds the base mapper's bank-select register and eight bank-data registers. It also holds a side file of eight extended 8-bit registers and a 2-bit CHR outer-bank register. Every CPU write is sorted into one of several classes. The current extended-register contents choose the class, and the write then lands in exactly one register or in none. All register contents go out on flat buses to the PRG and CHR address translators.

Three behaviours of the extended file affect the base registers:
- A mode bit sends every high-range write to the CHR outer register.
- A redirect mode sends data-port writes into the upper half of the extended file.
- When the CHR-RAM strap is set, two bank-select command values are exchanged on their way in, and a lock bit keeps the low three bits of extended register 0 cleared.

Interrupt counting, mirroring and PRG RAM protection writes are accepted and have no effect.

Top module: `mcart_regdec`

## Requirements
- R1: While reset is asserted, extended registers 0..3 hold 0x00 and 4..7 hold 0xFF. The CHR outer register, bank-select and all eight bank-data registers hold 0.
- R2: A write to 0x5000..0x5FFF with address bit 4 set stores the data byte in extended register addr[1:0].
- R3: While extended register 0 bit 6 is 1, any write at 0x8000 or above changes only the CHR outer register. That register becomes 0 if extended register 0 bits 5:4 are nonzero, and data[1:0] otherwise.
- R4: While extended register 0 bit 6 is 0, extended register 3 bit 1 is 1 and bank-select bit 3 is 1, a write to exactly 0x8001 stores the data in extended register 4 + bank-select[1:0]. No bank-data register changes.
- R5: Otherwise, a write to an even address in 0x8000..0x9FFF loads bank-select.
- R6: Otherwise, a write to an odd address in 0x8000..0x9FFF loads bank-data register bank-select[2:0].
- R7: With the CHR-RAM strap set, a bank-select write of 0x46 to exactly 0x8000 stores 0x47, and a write of 0x47 stores 0x46. Other values, other addresses and a cleared strap store the data unchanged.
- R8: With the CHR-RAM strap set, after any write in 0x5000..0x5FFF, bits 2:0 of extended register 0 are cleared when extended register 3 bit 1 (as just updated) is 1.
- R9: The CHR mode output equals bank-select bit 7 and the PRG mode output equals bank-select bit 6.
- R10: Writes at 0xA000 and above (outer mode off), writes in 0x5000..0x5FFF with address bit 4 clear, and writes below 0x5000 or in 0x6000..0x7FFF change no register, except for the R8 clear.
- R11: With the write strobe low, no register changes whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_ram_en | input | 1 | Variant strap: CHR-RAM board |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| ext_regs_o | output | 64 | Extended registers, register n at bits 8n+7..8n |
| bank_regs_o | output | 64 | Bank-data registers, register n at bits 8n+7..8n |
| bank_sel_o | output | 8 | Bank-select register |
| chr_outer_o | output | 2 | CHR outer-bank register |
| chr_mode_o | output | 1 | CHR mode bit |
| prg_mode_o | output | 1 | PRG mode bit |

## Verification
Every register is loaded at the clock edge where the strobe is sampled, and the result appears on the outputs in the same cycle. The R8 clear is applied within that same edge, not one cycle later. The bench drives each write on a falling edge and removes it on the next falling edge. It then compares every output field against its model at that falling edge, half a cycle after the capturing edge. The mode outputs are wires from bank-select, so they are checked at the same moment.

// File: rtl/mcart_pkg.sv
package mcart_pkg;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_LOW_EXT,
        WK_LOW_OTHER,
        WK_OUTER,
        WK_REDIR,
        WK_SELECT,
        WK_DATA
    } wr_kind_e;

    localparam logic [15:0] SEL_PORT_ADDR  = 16'h8000;
    localparam logic [15:0] DATA_PORT_ADDR = 16'h8001;
    localparam logic [7:0]  SWAP_CODE_A    = 8'h46;
    localparam logic [7:0]  SWAP_CODE_B    = 8'h47;

endpackage

// File: rtl/mcart_wr_classify.sv
module mcart_wr_classify
    import mcart_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              outer_mode,
    input  logic              redir_mode,
    input  logic              sel_redir,
    output wr_kind_e          kind
);

    logic high_rng;
    logic low_rng;
    logic port_rng;

    assign high_rng = addr[ADDR_W-1];
    assign low_rng  = (addr[ADDR_W-1:ADDR_W-4] == 4'h5);
    assign port_rng = (addr[ADDR_W-1:ADDR_W-3] == 3'b100);

    always_comb begin
        kind = WK_NONE;
        if (wr_en) begin
            if (high_rng) begin
                if (outer_mode) begin
                    kind = WK_OUTER;
                end else if (addr == DATA_PORT_ADDR && redir_mode && sel_redir) begin
                    kind = WK_REDIR;
                end else if (port_rng) begin
                    kind = addr[0] ? WK_DATA : WK_SELECT;
                end
            end else if (low_rng) begin
                kind = addr[4] ? WK_LOW_EXT : WK_LOW_OTHER;
            end
        end
    end

endmodule

// File: rtl/mcart_sel_swap.sv
module mcart_sel_swap
    import mcart_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              chr_ram_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);

    logic exact;

    assign exact = chr_ram_en && (addr == SEL_PORT_ADDR);

    always_comb begin
        data_out = data_in;
        if (exact) begin
            if (data_in == DATA_W'(SWAP_CODE_A)) begin
                data_out = DATA_W'(SWAP_CODE_B);
            end else if (data_in == DATA_W'(SWAP_CODE_B)) begin
                data_out = DATA_W'(SWAP_CODE_A);
            end
        end
    end

endmodule

// File: rtl/mcart_ext_lock.sv
module mcart_ext_lock #(
    parameter int DATA_W = 8,
    parameter int LOCK_W = 3
) (
    input  logic              low_wr,
    input  logic              chr_ram_en,
    input  logic              lock_bit,
    input  logic [DATA_W-1:0] ext0_in,
    output logic [DATA_W-1:0] ext0_out
);

    localparam logic [DATA_W-1:0] KEEP_MASK = ~DATA_W'((1 << LOCK_W) - 1);

    always_comb begin
        ext0_out = ext0_in;
        if (low_wr && chr_ram_en && lock_bit) begin
            ext0_out = ext0_in & KEEP_MASK;
        end
    end

endmodule

// File: rtl/mcart_regdec.sv
module mcart_regdec
    import mcart_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int OUTER_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chr_ram_en,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [8*DATA_W-1:0]    ext_regs_o,
    output logic [8*DATA_W-1:0]    bank_regs_o,
    output logic [DATA_W-1:0]      bank_sel_o,
    output logic [OUTER_W-1:0]     chr_outer_o,
    output logic                   chr_mode_o,
    output logic                   prg_mode_o
);

    localparam int N_EXT   = 8;
    localparam int N_BANK  = 8;
    localparam int EXT_IW  = $clog2(N_EXT);
    localparam int BANK_IW = $clog2(N_BANK);
    localparam int HALF    = N_EXT / 2;

    typedef struct packed {
        logic [N_EXT-1:0][DATA_W-1:0]  ext;
        logic [N_BANK-1:0][DATA_W-1:0] bank;
        logic [DATA_W-1:0]             sel;
        logic [OUTER_W-1:0]            outer;
    } regs_t;

    function automatic regs_t reset_regs();
        regs_t r;
        r = '0;
        for (int i = HALF; i < N_EXT; i++) begin
            r.ext[i] = '1;
        end
        return r;
    endfunction

    regs_t    regs_q;
    regs_t    regs_mid;
    regs_t    regs_d;
    wr_kind_e kind;
    logic [DATA_W-1:0] sel_in;
    logic [DATA_W-1:0] ext0_locked;
    logic              low_wr;

    mcart_wr_classify #(.ADDR_W(ADDR_W)) classify_i (
        .wr_en      (wr_en),
        .addr       (addr),
        .outer_mode (regs_q.ext[0][6]),
        .redir_mode (regs_q.ext[3][1]),
        .sel_redir  (regs_q.sel[3]),
        .kind       (kind)
    );

    mcart_sel_swap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) swap_i (
        .chr_ram_en (chr_ram_en),
        .addr       (addr),
        .data_in    (wdata),
        .data_out   (sel_in)
    );

    assign low_wr = (kind == WK_LOW_EXT) || (kind == WK_LOW_OTHER);

    always_comb begin
        regs_mid = regs_q;
        unique case (kind)
            WK_LOW_EXT: begin
                regs_mid.ext[EXT_IW'(addr[1:0])] = wdata;
            end
            WK_OUTER: begin
                if (|regs_q.ext[0][5:4]) begin
                    regs_mid.outer = '0;
                end else begin
                    regs_mid.outer = wdata[OUTER_W-1:0];
                end
            end
            WK_REDIR: begin
                regs_mid.ext[{1'b1, regs_q.sel[1:0]}] = wdata;
            end
            WK_SELECT: begin
                regs_mid.sel = sel_in;
            end
            WK_DATA: begin
                regs_mid.bank[regs_q.sel[BANK_IW-1:0]] = wdata;
            end
            default: begin
            end
        endcase
    end

    mcart_ext_lock #(.DATA_W(DATA_W), .LOCK_W(3)) lock_i (
        .low_wr     (low_wr),
        .chr_ram_en (chr_ram_en),
        .lock_bit   (regs_mid.ext[3][1]),
        .ext0_in    (regs_mid.ext[0]),
        .ext0_out   (ext0_locked)
    );

    always_comb begin
        regs_d        = regs_mid;
        regs_d.ext[0] = ext0_locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= reset_regs();
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        for (genvar g = 0; g < N_EXT; g++) begin : g_ext_out
            assign ext_regs_o[g*DATA_W +: DATA_W] = regs_q.ext[g];
        end
        for (genvar g = 0; g < N_BANK; g++) begin : g_bank_out
            assign bank_regs_o[g*DATA_W +: DATA_W] = regs_q.bank[g];
        end
    endgenerate

    assign bank_sel_o  = regs_q.sel;
    assign chr_outer_o = regs_q.outer;
    assign chr_mode_o  = regs_q.sel[7];
    assign prg_mode_o  = regs_q.sel[6];

endmodule

// File: rtl/mcart_regdec_chk.sv
module mcart_regdec_chk #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int OUTER_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chr_ram_en,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [8*DATA_W-1:0] ext_regs_o,
    input logic [8*DATA_W-1:0] bank_regs_o,
    input logic [DATA_W-1:0]   bank_sel_o,
    input logic [OUTER_W-1:0]  chr_outer_o
);

    logic [DATA_W-1:0] ext0;
    logic [DATA_W-1:0] ext3;
    logic              low_rng;

    assign ext0    = ext_regs_o[0 +: DATA_W];
    assign ext3    = ext_regs_o[3*DATA_W +: DATA_W];
    assign low_rng = (addr[ADDR_W-1:ADDR_W-4] == 4'h5);

    // R1: reset values
    a_r1_reset_values: assert property (@(posedge clk)
        (!rst_n) |=> (!rst_n && ext_regs_o == {{4{{DATA_W{1'b1}}}}, {4*DATA_W{1'b0}}}
                      && bank_regs_o == '0 && bank_sel_o == '0 && chr_outer_o == '0)
                     || rst_n);

    // R11: idle strobe
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ext_regs_o) && $stable(bank_regs_o)
                   && $stable(bank_sel_o) && $stable(chr_outer_o));

    // R3: outer mode keeps everything else still
    a_r3_outer_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1] && ext0[6]) |=> $stable(ext_regs_o)
            && $stable(bank_regs_o) && $stable(bank_sel_o));

    // R4: redirected data writes leave bank-data registers alone
    a_r4_redirect_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 16'h8001 && !ext0[6] && ext3[1] && bank_sel_o[3])
            |=> $stable(bank_regs_o) && $stable(bank_sel_o));

    // R10: upper range writes without outer mode change nothing
    a_r10_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:ADDR_W-3] >= 3'b101 && !ext0[6])
            |=> $stable(ext_regs_o) && $stable(bank_regs_o)
                && $stable(bank_sel_o) && $stable(chr_outer_o));

    // R8: lock clears ext0 low bits after a low-range write
    a_r8_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && low_rng && chr_ram_en) |=> (!ext3[1] || ext0[2:0] == 3'b000));

endmodule

bind mcart_regdec mcart_regdec_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OUTER_W(OUTER_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chr_ram_en (chr_ram_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .ext_regs_o (ext_regs_o),
    .bank_regs_o(bank_regs_o),
    .bank_sel_o (bank_sel_o),
    .chr_outer_o(chr_outer_o)
);

// File: tb/mcart_regdec_tb.sv
module mcart_regdec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chr_ram_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [63:0] ext_regs_o;
    logic [63:0] bank_regs_o;
    logic [7:0]  bank_sel_o;
    logic [1:0]  chr_outer_o;
    logic        chr_mode_o;
    logic        prg_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_ext  [8];
    logic [7:0] m_bank [8];
    logic [7:0] m_sel;
    logic [1:0] m_outer;

    always #2.5 clk = ~clk;

    mcart_regdec dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chr_ram_en (chr_ram_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .ext_regs_o (ext_regs_o),
        .bank_regs_o(bank_regs_o),
        .bank_sel_o (bank_sel_o),
        .chr_outer_o(chr_outer_o),
        .chr_mode_o (chr_mode_o),
        .prg_mode_o (prg_mode_o)
    );

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            cmp(tag, $sformatf("ext%0d", i), ext_regs_o[i*8 +: 8], m_ext[i]);
            cmp(tag, $sformatf("bank%0d", i), bank_regs_o[i*8 +: 8], m_bank[i]);
        end
        cmp(tag, "sel", bank_sel_o, m_sel);
        cmp(tag, "outer", {6'd0, chr_outer_o}, {6'd0, m_outer});
        cmp(tag, "chr_mode R9", {7'd0, chr_mode_o}, {7'd0, m_sel[7]});
        cmp(tag, "prg_mode R9", {7'd0, prg_mode_o}, {7'd0, m_sel[6]});
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_ext[i]  = (i < 4) ? 8'h00 : 8'hFF;
            m_bank[i] = 8'h00;
        end
        m_sel   = 8'h00;
        m_outer = 2'b00;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] v;
        if (a[15]) begin
            if (m_ext[0][6]) begin
                m_outer = (m_ext[0][5:4] != 0) ? 2'b00 : d[1:0];
            end else if (a == 16'h8001 && m_ext[3][1] && m_sel[3]) begin
                m_ext[4 + m_sel[1:0]] = d;
            end else if (a < 16'hA000) begin
                if (a[0]) begin
                    m_bank[m_sel[2:0]] = d;
                end else begin
                    v = d;
                    if (chr_ram_en && a == 16'h8000 && d == 8'h46) v = 8'h47;
                    else if (chr_ram_en && a == 16'h8000 && d == 8'h47) v = 8'h46;
                    m_sel = v;
                end
            end
        end else if (a[15:12] == 4'h5) begin
            if (a[4]) m_ext[a[1:0]] = d;
            if (chr_ram_en && m_ext[3][1]) m_ext[0][2:0] = 3'b000;
        end
    endtask

    task automatic do_reset(input logic variant);
        @(negedge clk);
        rst_n = 1'b0;
        chr_ram_en = variant;
        @(negedge clk);
        model_reset();
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        do_reset(1'b0);

        // R2: low-range sweep
        for (int a = 0; a < 4; a++) begin
            for (int k = 0; k < 4; k++) begin
                wr(16'h5010 | 16'(a) | 16'(k << 8) | 16'(k << 5), 8'(a * 37 + k * 11) & 8'hBF, "R2");
            end
        end
        do_reset(1'b0);

        // R10: ignored writes
        for (int a = 0; a < 4; a++) wr(16'h5000 | 16'(a) | 16'h0E20, 8'h77, "R10");
        wr(16'h4010, 8'h55, "R10");
        wr(16'h6011, 8'h55, "R10");
        wr(16'h7FFF, 8'h55, "R10");
        wr(16'hA000, 8'h55, "R10");
        wr(16'hC001, 8'h55, "R10");
        wr(16'hE000, 8'h55, "R10");
        wr(16'hFFFF, 8'h55, "R10");

        // R5 R6 R9: select and data ports, all indices
        for (int i = 0; i < 8; i++) begin
            wr((i % 2) ? 16'h9FFE : 16'h8000, 8'(i) | 8'(i << 6), "R5");
            wr((i % 2) ? 16'h9FFF : 16'h8001, 8'(i * 17 + 3), "R6");
        end

        // R4: redirect into upper extended registers
        wr(16'h5013, 8'h02, "R2");
        for (int k = 0; k < 4; k++) begin
            wr(16'h8000, 8'h08 | 8'(k), "R5");
            wr(16'h8001, 8'hC0 + 8'(k), "R4");
            wr(16'h8003, 8'h90 + 8'(k), "R6");
        end
        wr(16'h8000, 8'h02, "R5");
        wr(16'h8001, 8'h3C, "R6");
        do_reset(1'b0);

        // R3: outer-register mode for all bit 5:4 combinations
        for (int m = 0; m < 4; m++) begin
            wr(16'h5010, 8'h40 | 8'(m << 4), "R3");
            wr(16'h8000, 8'h03, "R3");
            wr(16'hE001, 8'h02, "R3");
            wr(16'hA001, 8'h01, "R3");
        end
        wr(16'h5010, 8'h00, "R3");
        wr(16'h8000, 8'h81, "R5");

        // R7: command swap only with strap set
        wr(16'h8000, 8'h46, "R7");
        do_reset(1'b1);
        wr(16'h8000, 8'h46, "R7");
        wr(16'h8000, 8'h47, "R7");
        wr(16'h8000, 8'h45, "R7");
        wr(16'h8002, 8'h46, "R7");
        wr(16'h8002, 8'h47, "R7");

        // R8: lock clear
        wr(16'h5010, 8'h07, "R8");
        wr(16'h5013, 8'h02, "R8");
        wr(16'h5010, 8'h1F, "R8");
        wr(16'h5000, 8'h33, "R8");
        wr(16'h5013, 8'h00, "R8");
        wr(16'h5010, 8'h05, "R8");
        do_reset(1'b0);
        wr(16'h5013, 8'h02, "R8");
        wr(16'h5010, 8'h07, "R8");

        // R11: strobe low
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            addr  = 16'h8000 + 16'(k) * 16'h1001;
            wdata = 8'(k * 29);
            @(negedge clk);
            check_all("R11");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule